// File: doc/BRIEF.md
# Amplifier Control and Status Two-Wire Slave

This block is the serial control port of a four-channel amplifier controller. It watches an oversampled two-wire bus (I2C protocol, 7-bit addressing), answers only to one fixed device address, and works in two fixed frame shapes. A write frame carries exactly two instruction bytes. Their defined bits drive the control outputs: diagnostics, offset test, gain per channel pair, mute per channel pair, clip threshold, fast mute, standby and line-driver thresholds. A read frame returns four status bytes, one per channel, built from the per-channel fault flags and a few system status inputs.

The status bytes are frozen into a shadow copy when the read address is acknowledged, so a transfer never mixes old and new fault states. When a read that delivered at least one status byte is closed by STOP, a one-cycle strobe tells the measurement logic to re-arm its diagnostic and offset windows. The SDA output is open-drain: the block only ever pulls the line low. Clock stretching, 10-bit addressing and general call are not handled.

Top module: `amp_ctrl_i2c_slave`

## Requirements
- R1: After reset every control output, `readDone` and `sdaOe` are 0. This means standby, all channels muted and diagnostics off.
- R2: Only the address byte 0xD8 (write) or 0xD9 (read) is acknowledged, with SDA pulled low in the ninth clock. Any other address gets no acknowledge, and the rest of that frame changes no output.
- R3: The first write byte drives these outputs: bit 6 `diagEn`, bit 5 `offsetEn`, bit 4 `gainLowFront`, bit 3 `gainLowRear`, bit 2 `unmuteFront`, bit 1 `unmuteRear`, bit 0 `clipHigh`. Bit 7 has no effect. Both instruction bytes are acknowledged.
- R4: The second write byte drives these outputs: bit 5 `fastMute`, bit 4 `ampOn`, bit 3 `lineDrv`. Its other bits have no effect.
- R5: A read returns four bytes in the order channel 0, 1, 2, 3, MSB first. In each byte, bits 3..0 are that channel's `chanFlags[4k+3:4k]`: {shorted load, offset, short to supply, short to ground}.
- R6: The status bytes carry these header bits. Byte 0: bit 7 `thermalWarn`, bit 6 `diagDone`. Byte 1: bit 7 `offsetActive`. Byte 2: bit 7 the `ampOn` control, bit 6 the `diagEn` control. All other header bits read 0.
- R7: Status values are captured when the read address is acknowledged. Input changes after that point do not appear in the bytes of that read.
- R8: `readDone` pulses for exactly one cycle on the STOP that ends a read in which at least one full status byte was sent. It does not pulse after a write, or after a read closed before any byte.
- R9: `sdaOe` changes only while SCL is low.
- R10: After the fourth status byte, or after the master does not acknowledge a byte, the slave releases SDA until the next START. Further bytes therefore read as 0xFF.
- R11: A third or later write byte is not acknowledged and changes no output.
- R12: A repeated START, without STOP, begins a new frame. This allows a write directly followed by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low (open drain) |
| chanFlags | input | 16 | Fault flags, 4 per channel, channel k at [4k+3:4k] |
| thermalWarn | input | 1 | Thermal warning status |
| diagDone | input | 1 | Diagnostic cycle finished |
| offsetActive | input | 1 | Offset measurement running |
| diagEn | output | 1 | Diagnostics enable |
| offsetEn | output | 1 | Offset detection enable |
| gainLowFront | output | 1 | Front pair low gain |
| gainLowRear | output | 1 | Rear pair low gain |
| unmuteFront | output | 1 | Front pair unmuted |
| unmuteRear | output | 1 | Rear pair unmuted |
| clipHigh | output | 1 | Clip detector at the higher threshold |
| fastMute | output | 1 | Short muting time |
| ampOn | output | 1 | Out of standby |
| lineDrv | output | 1 | Line-driver diagnostic thresholds |
| readDone | output | 1 | One-cycle strobe after a completed read |

## Verification
The status snapshot and a change of the live fault inputs can meet in the same read. The bench changes `chanFlags` and `thermalWarn` after the first status byte, then checks that the remaining bytes still match the values present at the address acknowledge. STOP detection and the end of a read also coincide, because the `readDone` strobe is raised by the same STOP that returns the state machine to idle. The bench counts strobes after write frames, after an address-only read, after a negatively acknowledged read and after a repeated-start read. Each count is judged against the rule that a pulse needs at least one delivered byte.

// File: rtl/amp_i2c_pkg.sv
package amp_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_CH = 4;
  localparam int FLAG_W = 4;
  localparam int WR_BYTES = 2;
  localparam int IDX_W = $clog2(NUM_CH);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_DATA,
    ST_WR_ACK, ST_RD_DATA, ST_RD_ACK, ST_WAIT_STOP
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             shiftIn;
    logic             rxBit;
    logic             shiftOut;
    logic             loadTx;
    logic             wrCtl;
    logic             capShadow;
    logic [IDX_W-1:0] idx;
  } dpStrobe_t;
endpackage

// File: rtl/amp_i2c_ctrl.sv
module amp_i2c_ctrl
  import amp_i2c_pkg::*;
#(
  parameter logic [6:0] DevAddr = 7'h6C,
  parameter int SyncStages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic             txMsb,
  output dpStrobe_t        strobe,
  output logic             sdaOe,
  output logic             readDone
);
  logic [SyncStages:0] sclPipe, sdaPipe;
  logic scl, sclPrev, sda, sdaPrev;
  logic sclRise, sclFall, startCond, stopCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SyncStages-1:0], sclIn};
      sdaPipe <= {sdaPipe[SyncStages-1:0], sdaIn};
    end
  end

  assign scl       = sclPipe[SyncStages-1];
  assign sclPrev   = sclPipe[SyncStages];
  assign sda       = sdaPipe[SyncStages-1];
  assign sdaPrev   = sdaPipe[SyncStages];
  assign sclRise   = scl && !sclPrev;
  assign sclFall   = !scl && sclPrev;
  assign startCond = scl && sclPrev && sdaPrev && !sda;
  assign stopCond  = scl && sclPrev && !sdaPrev && sda;

  busState_t        state, stNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic [IDX_W-1:0] byteIdx, idxNext;
  logic             isRead, rdNext, mAck, ackNext, rdSent, sentNext, doneNext;

  localparam logic [CNT_W-1:0] BitsFull = CNT_W'(BYTE_W);
  localparam logic [IDX_W-1:0] LastRd   = IDX_W'(NUM_CH - 1);
  localparam logic [IDX_W-1:0] WrLimit  = IDX_W'(WR_BYTES);

  always_comb begin
    stNext   = state;
    cntNext  = bitCnt;
    idxNext  = byteIdx;
    rdNext   = isRead;
    ackNext  = mAck;
    sentNext = rdSent;
    doneNext = 1'b0;
    strobe   = '0;
    strobe.idx   = byteIdx;
    strobe.rxBit = sda;
    if (startCond) begin
      stNext   = ST_ADDR;
      cntNext  = '0;
      sentNext = 1'b0;
    end else if (stopCond) begin
      stNext   = ST_IDLE;
      doneNext = rdSent;
      sentNext = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR_DATA: begin
          if (sclRise && bitCnt != BitsFull) begin
            strobe.shiftIn = 1'b1;
            cntNext = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == BitsFull) begin
            cntNext = '0;
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == DevAddr) begin
                stNext  = ST_ADDR_ACK;
                rdNext  = rxByte[0];
                idxNext = '0;
                strobe.capShadow = rxByte[0];
              end else begin
                stNext = ST_WAIT_STOP;
              end
            end else if (byteIdx < WrLimit) begin
              strobe.wrCtl = 1'b1;
              stNext = ST_WR_ACK;
            end else begin
              stNext = ST_WAIT_STOP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (isRead) begin
              strobe.loadTx = 1'b1;
              strobe.idx    = '0;
              stNext = ST_RD_DATA;
            end else begin
              stNext = ST_WR_DATA;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            idxNext = byteIdx + 1'b1;
            stNext  = ST_WR_DATA;
          end
        end
        ST_RD_DATA: begin
          if (sclRise && bitCnt != BitsFull) begin
            cntNext = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == BitsFull) begin
              cntNext  = '0;
              sentNext = 1'b1;
              stNext   = ST_RD_ACK;
            end else begin
              strobe.shiftOut = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) ackNext = !sda;
          if (sclFall) begin
            if (mAck && byteIdx != LastRd) begin
              idxNext = byteIdx + 1'b1;
              strobe.loadTx = 1'b1;
              strobe.idx    = byteIdx + 1'b1;
              stNext = ST_RD_DATA;
            end else begin
              stNext = ST_WAIT_STOP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteIdx  <= '0;
      isRead   <= 1'b0;
      mAck     <= 1'b0;
      rdSent   <= 1'b0;
      readDone <= 1'b0;
    end else begin
      state    <= stNext;
      bitCnt   <= cntNext;
      byteIdx  <= idxNext;
      isRead   <= rdNext;
      mAck     <= ackNext;
      rdSent   <= sentNext;
      readDone <= doneNext;
    end
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                 (state == ST_RD_DATA && !txMsb);
endmodule

// File: rtl/amp_i2c_dp.sv
module amp_i2c_dp
  import amp_i2c_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobe,
  input  logic [NUM_CH*FLAG_W-1:0] chanFlags,
  input  logic                     thermalWarn,
  input  logic                     diagDone,
  input  logic                     offsetActive,
  output logic [BYTE_W-1:0]        rxByte,
  output logic                     txMsb,
  output logic [6:0]               ctlA,
  output logic [2:0]               ctlB
);
  localparam int HDR_W = BYTE_W - FLAG_W;

  logic [BYTE_W-1:0] rxShift, txShift;
  logic [BYTE_W-1:0] liveStat [NUM_CH];
  logic [BYTE_W-1:0] shadow   [NUM_CH];
  logic [HDR_W-1:0]  hdr      [NUM_CH];

  assign hdr[0] = {thermalWarn, diagDone, {(HDR_W-2){1'b0}}};
  assign hdr[1] = {offsetActive, {(HDR_W-1){1'b0}}};
  assign hdr[2] = {ctlB[1], ctlA[6], {(HDR_W-2){1'b0}}};
  assign hdr[3] = '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign liveStat[g] = {hdr[g], chanFlags[g*FLAG_W +: FLAG_W]};
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shadow[g] <= '0;
      else if (strobe.capShadow) shadow[g] <= liveStat[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      ctlA    <= '0;
      ctlB    <= '0;
    end else begin
      if (strobe.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], strobe.rxBit};
      if (strobe.loadTx) txShift <= shadow[strobe.idx];
      else if (strobe.shiftOut) txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (strobe.wrCtl) begin
        if (strobe.idx == '0) ctlA <= rxShift[6:0];
        else ctlB <= rxShift[5:3];
      end
    end
  end

  assign rxByte = rxShift;
  assign txMsb  = txShift[BYTE_W-1];
endmodule

// File: rtl/amp_ctrl_i2c_slave.sv
module amp_ctrl_i2c_slave
  import amp_i2c_pkg::*;
#(
  parameter logic [6:0] DevAddr = 7'h6C,
  parameter int SyncStages = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOe,
  input  logic [15:0] chanFlags,
  input  logic        thermalWarn,
  input  logic        diagDone,
  input  logic        offsetActive,
  output logic        diagEn,
  output logic        offsetEn,
  output logic        gainLowFront,
  output logic        gainLowRear,
  output logic        unmuteFront,
  output logic        unmuteRear,
  output logic        clipHigh,
  output logic        fastMute,
  output logic        ampOn,
  output logic        lineDrv,
  output logic        readDone
);
  dpStrobe_t         strobe;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb;
  logic [6:0]        ctlA;
  logic [2:0]        ctlB;

  amp_i2c_ctrl #(.DevAddr(DevAddr), .SyncStages(SyncStages)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txMsb(txMsb), .strobe(strobe),
    .sdaOe(sdaOe), .readDone(readDone)
  );

  amp_i2c_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chanFlags(chanFlags),
    .thermalWarn(thermalWarn), .diagDone(diagDone), .offsetActive(offsetActive),
    .rxByte(rxByte), .txMsb(txMsb), .ctlA(ctlA), .ctlB(ctlB)
  );

  assign diagEn       = ctlA[6];
  assign offsetEn     = ctlA[5];
  assign gainLowFront = ctlA[4];
  assign gainLowRear  = ctlA[3];
  assign unmuteFront  = ctlA[2];
  assign unmuteRear   = ctlA[1];
  assign clipHigh     = ctlA[0];
  assign fastMute     = ctlB[2];
  assign ampOn        = ctlB[1];
  assign lineDrv      = ctlB[0];
endmodule

// File: rtl/amp_i2c_checker.sv
module amp_i2c_checker (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic sdaOe,
  input logic diagEn,
  input logic offsetEn,
  input logic gainLowFront,
  input logic gainLowRear,
  input logic unmuteFront,
  input logic unmuteRear,
  input logic clipHigh,
  input logic fastMute,
  input logic ampOn,
  input logic lineDrv,
  input logic readDone
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!sdaOe && !readDone && !diagEn && !ampOn && !unmuteFront && !unmuteRear));

  a_r9_sda_hold_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaOe));

  a_r3_ctl_hold_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable({diagEn, offsetEn, gainLowFront, gainLowRear,
                                          unmuteFront, unmuteRear, clipHigh}));

  a_r4_ctl_hold_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable({fastMute, ampOn, lineDrv}));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    readDone |=> !readDone);

  a_r8_done_at_stop: assert property (@(posedge clk) disable iff (!rstN)
    readDone |-> (sclIn && sdaIn && !sdaOe));
endmodule

bind amp_ctrl_i2c_slave amp_i2c_checker u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaOe(sdaOe),
  .diagEn(diagEn), .offsetEn(offsetEn), .gainLowFront(gainLowFront),
  .gainLowRear(gainLowRear), .unmuteFront(unmuteFront), .unmuteRear(unmuteRear),
  .clipHigh(clipHigh), .fastMute(fastMute), .ampOn(ampOn), .lineDrv(lineDrv),
  .readDone(readDone)
);

// File: tb/amp_ctrl_i2c_slave_bench.sv
`timescale 1ns/1ps
module amp_ctrl_i2c_slave_bench;
  localparam time Q = 50ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaLine, sdaOe;
  logic [15:0] chanFlags = '0;
  logic thermalWarn = 1'b0, diagDone = 1'b0, offsetActive = 1'b0;
  logic diagEn, offsetEn, gainLowFront, gainLowRear, unmuteFront, unmuteRear;
  logic clipHigh, fastMute, ampOn, lineDrv, readDone;

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  amp_ctrl_i2c_slave u_amp_ctrl_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .chanFlags(chanFlags), .thermalWarn(thermalWarn), .diagDone(diagDone),
    .offsetActive(offsetActive), .diagEn(diagEn), .offsetEn(offsetEn),
    .gainLowFront(gainLowFront), .gainLowRear(gainLowRear),
    .unmuteFront(unmuteFront), .unmuteRear(unmuteRear), .clipHigh(clipHigh),
    .fastMute(fastMute), .ampOn(ampOn), .lineDrv(lineDrv), .readDone(readDone)
  );

  int nChecks = 0, nErrors = 0, doneCnt = 0;
  bit finished = 0;
  logic expAmpOn = 1'b0, expDiag = 1'b0;

  always @(posedge clk) if (readDone) doneCnt++;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { string req; logic [7:0] val; } item_t;
  item_t expQ[$];
  logic [7:0] gotQ[$];
  event gotEv;

  initial forever begin
    @(gotEv);
    while (gotQ.size() > 0) begin
      logic [7:0] g;
      g = gotQ.pop_front();
      if (expQ.size() == 0) check("scoreboard-underflow", g, -1);
      else begin
        item_t e;
        e = expQ.pop_front();
        check(e.req, g, e.val);
      end
    end
  end

  function automatic logic [7:0] statByte(int k);
    case (k)
      0: return {thermalWarn, diagDone, 2'b00, chanFlags[3:0]};
      1: return {offsetActive, 3'b000, chanFlags[7:4]};
      2: return {expAmpOn, expDiag, 2'b00, chanFlags[11:8]};
      default: return {4'b0000, chanFlags[15:12]};
    endcase
  endfunction

  task automatic busStart();
    sdaM = 1; #Q; sclM = 1; #Q; sdaM = 0; #Q; sclM = 0; #Q;
  endtask
  task automatic busStop();
    sdaM = 0; #Q; sclM = 1; #Q; sdaM = 1; #Q;
  endtask
  task automatic wBit(input logic b);
    sdaM = b; #Q; sclM = 1; #(2*Q); sclM = 0; #Q;
  endtask
  task automatic rBit(output logic b);
    sdaM = 1; #Q; sclM = 1; #Q; b = sdaLine; #Q; sclM = 0; #Q;
  endtask
  task automatic wByte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) wBit(v[i]);
    rBit(x);
    ack = ~x;
  endtask
  task automatic rByte(input logic giveAck, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rBit(v[i]);
    wBit(~giveAck);
  endtask

  task automatic writeRegs(input logic [7:0] a, input logic [7:0] b);
    logic ack;
    busStart();
    wByte(8'hD8, ack); check("R2 write address ack", ack, 1);
    wByte(a, ack);     check("R3 first byte ack", ack, 1);
    wByte(b, ack);     check("R4 second byte ack", ack, 1);
    busStop();
    expDiag = a[6]; expAmpOn = b[4];
  endtask

  task automatic checkCtl(input string req, input logic [7:0] a, input logic [7:0] b);
    check({req, " first-byte fields"},
          {diagEn, offsetEn, gainLowFront, gainLowRear, unmuteFront, unmuteRear, clipHigh},
          a[6:0]);
    check({req, " second-byte fields"}, {fastMute, ampOn, lineDrv}, b[5:3]);
  endtask

  // read n bytes with ack on all but the last unless ackLast
  task automatic readBytes(input int n, input logic ackLast, input string req);
    logic ack;
    logic [7:0] v;
    busStart();
    wByte(8'hD9, ack); check("R2 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      expQ.push_back('{req, (k < 4) ? statByte(k) : 8'hFF});
    end
    for (int k = 0; k < n; k++) begin
      rByte((k < n - 1) || ackLast, v);
      gotQ.push_back(v); ->gotEv;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      nChecks++; nErrors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] v;
    int d0;
    #23 rstN = 1;
    #40;
    // R1 reset state
    checkCtl("R1 reset", 8'h00, 8'h00);
    check("R1 reset sdaOe", sdaOe, 0);
    check("R1 reset readDone", readDone, 0);

    // R3/R4 first pattern
    writeRegs(8'h55, 8'h38);
    #Q; checkCtl("R3 R4 pattern 55/38", 8'h55, 8'h38);
    check("R8 no strobe after write", doneCnt, 0);

    // undefined bits set, no effect (R3 bit7, R4 others)
    writeRegs(8'hAA, 8'hD7);
    #Q; checkCtl("R3 R4 pattern AA/D7", 8'h2A, 8'h10);

    // R2 wrong addresses
    busStart(); wByte(8'hDA, ack); check("R2 no ack for DA", ack, 0);
    wByte(8'hFF, ack); wByte(8'hFF, ack); busStop();
    busStart(); wByte(8'h58, ack); check("R2 no ack for 58", ack, 0);
    wByte(8'h7F, ack); wByte(8'hFF, ack); busStop();
    #Q; checkCtl("R2 controls unchanged", 8'h2A, 8'h10);

    // R5 R6 plain read
    chanFlags = 16'h9A53; thermalWarn = 0; diagDone = 1; offsetActive = 1;
    d0 = doneCnt;
    readBytes(4, 1'b0, "R5 R6 status byte");
    busStop(); #Q;
    check("R8 one strobe after read", doneCnt, d0 + 1);

    // R7 snapshot: change inputs after first byte
    chanFlags = 16'h1234; thermalWarn = 1; diagDone = 0; offsetActive = 0;
    busStart(); wByte(8'hD9, ack); check("R7 read address ack", ack, 1);
    for (int k = 0; k < 4; k++) expQ.push_back('{"R7 snapshot byte", statByte(k)});
    rByte(1'b1, v); gotQ.push_back(v); ->gotEv;
    chanFlags = 16'hEDCB; thermalWarn = 0; offsetActive = 1;
    for (int k = 1; k < 4; k++) begin
      rByte(k < 3, v); gotQ.push_back(v); ->gotEv;
    end
    busStop();

    // R10 five bytes, fifth released
    chanFlags = 16'h0F0F;
    readBytes(5, 1'b0, "R10 R5 five-byte read");
    busStop();

    // R10 nack after second byte
    d0 = doneCnt;
    readBytes(2, 1'b0, "R10 nack read");
    #Q; check("R10 released after nack", sdaOe, 0);
    rBit(ack); check("R10 line high after nack", ack, 1);
    busStop(); #Q;
    check("R8 strobe after nack read", doneCnt, d0 + 1);

    // R8 address-only read (byte 0 MSB is 1 so STOP is possible)
    thermalWarn = 1;
    d0 = doneCnt;
    busStart(); wByte(8'hD9, ack); check("R8 addr-only ack", ack, 1);
    busStop(); #Q;
    check("R8 no strobe without byte", doneCnt, d0);
    thermalWarn = 0;

    // R11 extra write byte
    busStart(); wByte(8'hD8, ack);
    wByte(8'h7F, ack); wByte(8'h38, ack);
    wByte(8'h00, ack); check("R11 third byte not acked", ack, 0);
    busStop(); expDiag = 1; expAmpOn = 1;
    #Q; checkCtl("R11 controls keep 7F/38", 8'h7F, 8'h38);

    // R12 repeated start: write then read
    d0 = doneCnt;
    busStart(); wByte(8'hD8, ack);
    wByte(8'h40, ack); wByte(8'h10, ack);
    expDiag = 1; expAmpOn = 1;
    chanFlags = 16'h5A3C;
    readBytes(4, 1'b0, "R12 read after repeated start");
    busStop(); #Q;
    checkCtl("R12 write before repeated start", 8'h40, 8'h10);
    check("R12 strobe after combined frame", doneCnt, d0 + 1);

    #Q; ->gotEv; #1;
    check("scoreboard drained", expQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule